// File: doc/BRIEF.md
# Load Element Width and Saturation Converter

This block takes one 64-bit word returned by a memory read and turns it into the element value that goes into the register file. It keeps only the bytes of the operation width and may reverse their order. It then resizes the value to the source element width, and finally resizes or saturates it to the destination element width. The result is left in the low bits of a 64-bit output bus, with zeros above the destination width.

Byte reversal is enabled when the byte-reverse instruction flag and the little-endian mode flag are equal. In plain mode every resize is a zero-extension or a truncation. In saturated mode the value is sign-extended from the operation width to the source width, then clamped to the destination width, either signed or unsigned. The conversion is combinational. A parameter adds one output register, and that register is on by default.

Top module: `ld_elem_convert`

## Requirements
- R1: While reset (`rst_n` low) is active, `elem_out` is zero.
- R2: With `OUT_REG`=1, `elem_out` shows the conversion of the inputs sampled at the previous rising clock edge.
- R3: Bytes are reversed when `brev_op` equals `le_mode`, and are left in order when the two flags differ.
- R4: Reversal swaps only the bytes inside the operation width. Read-data bytes above the operation width have no effect on the result.
- R5: Width codes are 0=8, 1=16, 2=32 and 3=64 bits. With `sat_en`=0, the result is the value truncated to the smallest of the operation, source and destination widths, zero-extended.
- R6: With `sat_en`=1 and an operation width narrower than the source width, the value is sign-extended to the source width before the destination step.
- R7: With `sat_en`=1 and `sat_signed`=1, a source value above the largest signed destination value gives 0111..1, and a value below the most negative one gives 1000..0, each at the destination width.
- R8: With `sat_en`=1 and `sat_signed`=0, a source value, read as unsigned, that exceeds the destination range gives all ones at the destination width.
- R9: In saturated mode, when the destination is at least as wide as the source, nothing is clamped. A signed result is sign-extended to the destination width and an unsigned result is zero-extended.
- R10: Every bit of `elem_out` above the destination width is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_data | input | 64 | Raw memory read word |
| op_wid | input | 2 | Operation width code |
| brev_op | input | 1 | Byte-reverse instruction variant flag |
| le_mode | input | 1 | Processor little-endian flag |
| src_wid | input | 2 | Source element width code |
| dst_wid | input | 2 | Destination element width code |
| sat_en | input | 1 | Saturated conversion enable |
| sat_signed | input | 1 | 1 = signed saturation, 0 = unsigned |
| elem_out | output | 64 | Converted element, low-aligned |

## Verification
The hardest cases to reach are saturated loads where the operation is narrower than the source width and the top bit of the loaded value is set. Sign extension then turns a small byte into a large negative number or a large unsigned number, and that number must clamp. Random words almost never line up with the clamp boundaries, so directed vectors place 0x80 and 0x7F style bytes at the operation width under each signedness. A behavioural model, built from byte loops and integer comparisons, checks a long random stream on every clock.

// File: rtl/ld_elem_convert.sv
module ld_elem_convert #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] rd_data,
  input  logic [1:0]  op_wid,
  input  logic        brev_op,
  input  logic        le_mode,
  input  logic [1:0]  src_wid,
  input  logic [1:0]  dst_wid,
  input  logic        sat_en,
  input  logic        sat_signed,
  output logic [63:0] elem_out
);
  localparam int NBYTE = 8;

  function automatic logic [63:0] wmask(input logic [1:0] c);
    case (c)
      2'd0:    wmask = 64'h0000_0000_0000_00FF;
      2'd1:    wmask = 64'h0000_0000_0000_FFFF;
      2'd2:    wmask = 64'h0000_0000_FFFF_FFFF;
      default: wmask = '1;
    endcase
  endfunction

  function automatic logic [63:0] sext(input logic [63:0] v, input logic [1:0] c);
    case (c)
      2'd0:    sext = {{56{v[7]}},  v[7:0]};
      2'd1:    sext = {{48{v[15]}}, v[15:0]};
      2'd2:    sext = {{32{v[31]}}, v[31:0]};
      default: sext = v;
    endcase
  endfunction

  logic        do_swap;
  logic [3:0]  nbytes;
  logic [63:0] swapped, opval, srcv, ssrc, hi_lim, conv;

  assign do_swap = ~(brev_op ^ le_mode);
  assign nbytes  = 4'd1 << op_wid;

  always_comb begin
    swapped = '0;
    for (int i = 0; i < NBYTE; i++) begin
      if (4'(i) < nbytes)
        swapped[8*i +: 8] = rd_data[8*(int'(nbytes) - 1 - i) +: 8];
    end
  end

  assign opval  = (do_swap ? swapped : rd_data) & wmask(op_wid);
  assign srcv   = sat_en ? (sext(opval, op_wid) & wmask(src_wid)) : (opval & wmask(src_wid));
  assign ssrc   = sext(srcv, src_wid);
  assign hi_lim = wmask(dst_wid) >> 1;

  always_comb begin
    conv = srcv;
    if (sat_en && dst_wid != 2'd3) begin
      if (sat_signed) begin
        if ($signed(ssrc) > $signed(hi_lim))       conv = hi_lim;
        else if ($signed(ssrc) < $signed(~hi_lim)) conv = ~hi_lim;
        else                                       conv = ssrc;
      end else if (srcv > wmask(dst_wid)) begin
        conv = wmask(dst_wid);
      end
    end else if (sat_en && sat_signed) begin
      conv = ssrc;
    end
    conv = conv & wmask(dst_wid);
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) elem_out <= '0;
        else        elem_out <= conv;
      end
    end else begin : g_comb
      assign elem_out = rst_n ? conv : '0;
    end
  endgenerate
endmodule

// File: rtl/ld_elem_convert_chk.sv
module ld_elem_convert_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] rd_data,
  input logic [1:0]  op_wid,
  input logic        brev_op,
  input logic        le_mode,
  input logic [1:0]  src_wid,
  input logic [1:0]  dst_wid,
  input logic        sat_en,
  input logic        sat_signed,
  input logic [63:0] elem_out
);
  function automatic logic [63:0] dmask(input logic [1:0] c);
    dmask = (c == 2'd3) ? '1 : ((64'd1 << (8 << c)) - 64'd1);
  endfunction

  generate
    if (OUT_REG) begin : g_chk
      // R1
      reset_zero_chk: assert property (@(posedge clk) !rst_n |=> elem_out == 64'd0);

      // R10
      upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (elem_out & ~dmask($past(dst_wid))) == 64'd0);

      // R5
      byte_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_en && op_wid == 2'd0) |=> elem_out == {56'd0, $past(rd_data[7:0])});

      // R8
      usat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en && !sat_signed && op_wid == 2'd3 && src_wid == 2'd3 && dst_wid == 2'd0
         && brev_op != le_mode && rd_data[63:8] != 56'd0) |=> elem_out == 64'hFF);

      // R7
      ssat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en && sat_signed && op_wid == 2'd3 && src_wid == 2'd3 && dst_wid == 2'd0
         && brev_op != le_mode && $signed(rd_data) > 64'sd127) |=> elem_out == 64'h7F);
    end
  endgenerate
endmodule

bind ld_elem_convert ld_elem_convert_chk #(.OUT_REG(OUT_REG)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .op_wid(op_wid), .brev_op(brev_op),
  .le_mode(le_mode), .src_wid(src_wid), .dst_wid(dst_wid), .sat_en(sat_en),
  .sat_signed(sat_signed), .elem_out(elem_out)
);

// File: tb/ld_elem_convert_tb_top.sv
module ld_elem_convert_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] rd_data = '0;
  logic [1:0]  op_wid = '0, src_wid = '0, dst_wid = '0;
  logic        brev_op = 1'b0, le_mode = 1'b0, sat_en = 1'b0, sat_signed = 1'b0;
  logic [63:0] elem_out;

  int n_run = 0, n_fail = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  ld_elem_convert dut_i (
    .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .op_wid(op_wid), .brev_op(brev_op),
    .le_mode(le_mode), .src_wid(src_wid), .dst_wid(dst_wid), .sat_en(sat_en),
    .sat_signed(sat_signed), .elem_out(elem_out)
  );

  function automatic logic [63:0] lowbits(input int w);
    return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] model(input logic [63:0] d, input int op, input logic br,
      input logic le, input int sr, input int ds, input logic sat, input logic sg);
    int ob = 1 << op, ow = 8 << op, sw = 8 << sr, dw = 8 << ds;
    logic [63:0] v = '0, s;
    longint sv, hi, lo;
    for (int b = 0; b < ob; b++)
      v[8*((br == le) ? (ob - 1 - b) : b) +: 8] = d[8*b +: 8];
    if (!sat) begin
      int k = ow;
      if (sw < k) k = sw;
      if (dw < k) k = dw;
      return v & lowbits(k);
    end
    if (ow < 64 && v[ow-1]) v = v | ~lowbits(ow);
    s = v & lowbits(sw);
    if (sg) begin
      sv = longint'(s);
      if (sw < 64 && s[sw-1]) sv = longint'(s | ~lowbits(sw));
      if (dw < 64) begin
        hi = (64'sd1 <<< (dw - 1)) - 1;
        lo = -(64'sd1 <<< (dw - 1));
        if (sv > hi) sv = hi;
        if (sv < lo) sv = lo;
      end
      return 64'(sv) & lowbits(dw);
    end
    if (dw < 64 && s > lowbits(dw)) s = lowbits(dw);
    return s & lowbits(dw);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [63:0] d, input int op, input logic br,
      input logic le, input int sr, input int ds, input logic sat, input logic sg,
      input logic [63:0] exp);
    @(negedge clk);
    if (exp_q.size() > 0) check(tag_q.pop_front(), elem_out, exp_q.pop_front());
    rd_data = d; op_wid = 2'(op); brev_op = br; le_mode = le;
    src_wid = 2'(sr); dst_wid = 2'(ds); sat_en = sat; sat_signed = sg;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic vec(input string tag, input logic [63:0] d, input int op, input logic br,
      input logic le, input int sr, input int ds, input logic sat, input logic sg,
      input logic [63:0] exp);
    // directed expectation cross-checked against the bench model too
    check({tag, " model"}, model(d, op, br, le, sr, ds, sat, sg), exp);
    apply(tag, d, op, br, le, sr, ds, sat, sg, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    rd_data = 64'hDEAD_BEEF_0123_4567; sat_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", elem_out, 64'd0);
    rst_n = 1'b1;
    sat_en = 1'b0;
    // R3: equal flags swap, differing flags keep order
    vec("R3 swap", 64'h0000_0000_0102_0304, 2, 0, 0, 3, 3, 0, 0, 64'h0403_0201);
    vec("R3 noswap", 64'h0000_0000_0102_0304, 2, 0, 1, 3, 3, 0, 0, 64'h0102_0304);
    vec("R3 swap64", 64'h0102_0304_0506_0708, 3, 1, 1, 3, 3, 0, 0, 64'h0807_0605_0403_0201);
    // R4: only op-width bytes swap, upper bytes ignored
    vec("R4 half", 64'hAABB_CCDD_1122_3344, 1, 1, 1, 3, 3, 0, 0, 64'h4433);
    vec("R4 upper", 64'hFFFF_FFFF_FFFF_0012, 0, 1, 0, 3, 3, 0, 0, 64'h12);
    // R5 / R10: plain truncation to the narrowest width
    vec("R5 src16", 64'hFFFF_FFFF_FFFF_FFFF, 3, 1, 0, 1, 3, 0, 0, 64'hFFFF);
    vec("R5 dst8", 64'h1234_5678_9ABC_DEF0, 3, 1, 0, 3, 0, 0, 0, 64'hF0);
    vec("R10 zeroext", 64'h0000_0000_0000_0080, 0, 1, 0, 3, 3, 0, 0, 64'h80);
    // R6: sign extension from op width
    vec("R6 sext", 64'h0000_0000_0000_0080, 0, 1, 0, 2, 2, 1, 1, 64'hFFFF_FF80);
    // R7: signed clamps
    vec("R7 pos", 64'h0000_0000_0000_1000, 2, 1, 0, 2, 0, 1, 1, 64'h7F);
    vec("R7 neg", 64'h0000_0000_FFFF_0000, 2, 1, 0, 2, 0, 1, 1, 64'h80);
    vec("R7 inrange", 64'h0000_0000_FFFF_FFF0, 2, 1, 0, 2, 0, 1, 1, 64'hF0);
    // R8: unsigned clamps
    vec("R8 big", 64'h0000_0000_0000_0100, 2, 1, 0, 2, 0, 1, 0, 64'hFF);
    vec("R8 fits", 64'h0000_0000_0000_0080, 2, 1, 0, 2, 0, 1, 0, 64'h80);
    vec("R8 sextbig", 64'h0000_0000_0000_0080, 0, 1, 0, 1, 0, 1, 0, 64'hFF);
    // R9: no clamp when destination is wider
    vec("R9 signed", 64'h0000_0000_0000_8000, 1, 1, 0, 3, 3, 1, 1, 64'hFFFF_FFFF_FFFF_8000);
    vec("R9 unsigned", 64'h0000_0000_0000_8000, 1, 1, 0, 1, 2, 1, 0, 64'h8000);
    // R2: random stream, model compared every clock
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] d = {$urandom, $urandom};
      int op = $urandom_range(0, 3), sr = $urandom_range(0, 3), ds = $urandom_range(0, 3);
      logic br = 1'($urandom), le = 1'($urandom), sat = 1'($urandom), sg = 1'($urandom);
      apply("R2 stream", d, op, br, le, sr, ds, sat, sg, model(d, op, br, le, sr, ds, sat, sg));
    end
    @(negedge clk);
    check(tag_q.pop_front(), elem_out, exp_q.pop_front());
    // R1: reset mid-run clears output
    rd_data = '1; sat_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 midrun", elem_out, 64'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule